// File: doc/BRIEF.md
# Cascadable Serial Configuration Store

This block is the read side of a one-bit-wide configuration memory. A bit array of parameterised depth is read one bit per rising clock edge. An internal counter steps the read address. The current bit appears on a data output that can float. A consuming device clocks the store and samples one bit per edge until it has received its full bitstream.

Several stores can be chained. The chip-enable output of one store drives the active-low chip-enable of the next. Each store drives the shared data line only while it holds live data. Once a store has delivered its last bit, it hands the line to its neighbour. Together the stores read out as one long stream.

The reset/output-enable pin has a polarity set by a parameter. When that pin is in its reset state, it resets the counter and floats the output. A simple synchronous load port fills the array.

Top module: `serial_cfg_store`

## Requirements
- R1: On a rising clock edge, the read counter advances by one address only if chip-enable (`ce_n` low) and output-enable (reset pin not in its reset state) are both active. The counter never advances on any other edge.
- R2: While the reset pin is in its reset state, `dout_en` is low and `ceo_n` is high. Every clock edge in that state returns the counter to address 0, so the first bit after release is the bit at address 0.
- R3: With `RST_HIGH` = 1 (the default), `rst_oe` = 1 means reset. With `RST_HIGH` = 0, `rst_oe` = 0 means reset.
- R4: While `ce_n` is high, `dout_en` is low and `ceo_n` is high, whatever the reset pin does, and the counter keeps its value.
- R5: `ceo_n` is low only when chip-enable and output-enable are both active and the counter has moved past the last address. From then on it tracks `ce_n` for as long as output-enable stays active.
- R6: The edge after the bit at the highest address (DEPTH-1) is read sets the past-end state. In that state `dout_en` is low, `ceo_n` is low, and further edges leave the counter unchanged until the next reset.
- R7: Without a reset, taking chip-enable away and giving it back resumes the read at the address where it stopped.
- R8: While `dout_en` is high, `dout` equals the stored bit at the current address, without waiting for a clock edge.
- R9: A rising edge with `ld_en` high writes `ld_bit` to address `ld_addr`.
- R10: In a chain where each `ceo_n` drives the next `ce_n`, at most one store asserts `dout_en` at a time. The shared line carries the first store's bits and then the second store's bits, with no gap and no repeated bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; each rising edge may step the counter |
| ce_n | input | 1 | Chip-enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable; polarity set by `RST_HIGH` |
| ld_en | input | 1 | Load strobe for the array |
| ld_addr | input | AW | Load address, AW = clog2(DEPTH) |
| ld_bit | input | 1 | Bit to store |
| dout | output | 1 | Data value at the current address (0 while floating) |
| dout_en | output | 1 | High when `dout` drives the line |
| ceo_n | output | 1 | Chip-enable to the next store in a chain, active low |

## Verification
The hardest state to reach is the handover between chained stores. The first store must go past its end in the same edge that the second store's enable takes effect, and the bench then observes both stores on one shared line. The stimulus releases reset on a two-store chain and clocks it through both arrays. It then drops chip-enable after the chain is past its end, and checks that the cascade output tracks it while the counters hold. A second pass interrupts the read mid-stream without a reset, so the stream must resume at the address where it stopped.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // Decoded control levels, all active high.
    typedef struct packed {
        logic rst;
        logic oe;
        logic ce;
    } cfgp_ctl_t;

    // Address width for a given depth; at least one bit.
    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/cfgp_pin_decode.sv
module cfgp_pin_decode #(
    parameter bit RST_HIGH = 1'b1
) (
    input  logic                 ce_n,
    input  logic                 rst_oe,
    output cfgp_pkg::cfgp_ctl_t  ctl
);

    logic rst_raw;

    generate
        if (RST_HIGH) begin : g_rst_high
            assign rst_raw = rst_oe;
        end else begin : g_rst_low
            assign rst_raw = ~rst_oe;
        end
    endgenerate

    always_comb begin
        ctl.rst = rst_raw;
        ctl.oe  = ~rst_raw;
        ctl.ce  = ~ce_n;
    end

endmodule

// File: rtl/cfgp_addr_ctr.sv
module cfgp_addr_ctr #(
    parameter  int DEPTH = 256,
    localparam int AW    = cfgp_pkg::addr_bits(DEPTH)
) (
    input  logic                 clk,
    input  cfgp_pkg::cfgp_ctl_t  ctl,
    output logic [AW:0]          count
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW:0] cnt_q;
    logic [AW:0] cnt_d;
    logic        step;

    // Top bit is the past-end flag; once set the counter holds.
    always_comb begin
        step  = ctl.ce & ctl.oe & ~cnt_q[AW];
        cnt_d = cnt_q;
        if (ctl.rst) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q[AW-1:0] == LAST) begin
                cnt_d = {1'b1, {AW{1'b0}}};
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/cfgp_bit_array.sv
module cfgp_bit_array #(
    parameter  int DEPTH = 256,
    localparam int AW    = cfgp_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic mem [DEPTH];

    generate
        if (DEPTH == (1 << AW)) begin : g_full
            always_ff @(posedge clk) begin
                if (wr_en) begin
                    mem[wr_addr] <= wr_bit;
                end
            end
            assign rd_bit = mem[rd_addr];
        end else begin : g_partial
            always_ff @(posedge clk) begin
                if (wr_en && (int'(wr_addr) < DEPTH)) begin
                    mem[wr_addr] <= wr_bit;
                end
            end
            assign rd_bit = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 1'b0;
        end
    endgenerate

endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store #(
    parameter  int DEPTH    = 256,
    parameter  bit RST_HIGH = 1'b1,
    localparam int AW       = cfgp_pkg::addr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          ce_n,
    input  logic          rst_oe,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_bit,
    output logic          dout,
    output logic          dout_en,
    output logic          ceo_n
);

    cfgp_pkg::cfgp_ctl_t ctl;
    logic [AW:0]         count_q;
    logic                past_end;
    logic                rd_bit;
    logic                selected;

    cfgp_pin_decode #(.RST_HIGH(RST_HIGH)) u_decode (
        .ce_n   (ce_n),
        .rst_oe (rst_oe),
        .ctl    (ctl)
    );

    cfgp_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk   (clk),
        .ctl   (ctl),
        .count (count_q)
    );

    cfgp_bit_array #(.DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_bit  (ld_bit),
        .rd_addr (count_q[AW-1:0]),
        .rd_bit  (rd_bit)
    );

    assign past_end = count_q[AW];
    assign selected = ctl.ce & ctl.oe;

    always_comb begin
        dout_en = selected & ~past_end;
        dout    = dout_en ? rd_bit : 1'b0;
        ceo_n   = ~(selected & past_end);
    end

endmodule

// File: rtl/serial_cfg_store_chk.sv
module serial_cfg_store_chk #(
    parameter  int DEPTH    = 256,
    parameter  bit RST_HIGH = 1'b1,
    localparam int AW       = cfgp_pkg::addr_bits(DEPTH)
) (
    input logic        clk,
    input logic        ce_n,
    input logic        rst_oe,
    input logic        dout_en,
    input logic        ceo_n,
    input logic [AW:0] count
);

    logic rst_act;
    logic seen_rst = 1'b0;

    assign rst_act = RST_HIGH ? rst_oe : ~rst_oe;

    always_ff @(posedge clk) begin
        if (rst_act) begin
            seen_rst <= 1'b1;
        end
    end

    // R2: reset floats the output and keeps the cascade output high
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!seen_rst)
        rst_act |-> (!dout_en && ceo_n));

    // R2: a reset edge leaves the counter at zero
    a_r2_reset_zero: assert property (@(posedge clk) disable iff (!seen_rst)
        rst_act |=> (count == '0));

    // R4: chip-enable inactive idles both outputs
    a_r4_idle_outputs: assert property (@(posedge clk) disable iff (rst_act || !seen_rst)
        ce_n |-> (!dout_en && ceo_n));

    // R4: chip-enable inactive freezes the counter
    a_r4_frozen: assert property (@(posedge clk) disable iff (rst_act || !seen_rst)
        ce_n |=> $stable(count));

    // R1: a live read edge moves the counter
    a_r1_step: assert property (@(posedge clk) disable iff (rst_act || !seen_rst)
        (!ce_n && dout_en) |=> (count != $past(count)));

    // R6: past the end the counter no longer moves
    a_r6_hold_end: assert property (@(posedge clk) disable iff (rst_act || !seen_rst)
        !ceo_n |=> $stable(count));

    // R5: cascade output and data drive never overlap
    a_r5_ceo_excl: assert property (@(posedge clk) disable iff (rst_act || !seen_rst)
        !ceo_n |-> !dout_en);

endmodule

bind serial_cfg_store serial_cfg_store_chk #(
    .DEPTH    (DEPTH),
    .RST_HIGH (RST_HIGH)
) u_chk (
    .clk     (clk),
    .ce_n    (ce_n),
    .rst_oe  (rst_oe),
    .dout_en (dout_en),
    .ceo_n   (ceo_n),
    .count   (count_q)
);

// File: tb/serial_cfg_store_test.sv
module serial_cfg_store_test;

    localparam int D  = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rlo, rhi, ce_a, ce_c;
    logic          ld_a, ld_b, ld_c, ld_bit;
    logic [AW-1:0] ld_addr;
    logic          d_a, e_a, co_a, d_b, e_b, co_b, d_c, e_c, co_c;
    logic          line;

    int    checks = 0;
    int    errors = 0;
    string tag    = "R2";

    // first store of a chain, active-low reset
    serial_cfg_store #(.DEPTH(D), .RST_HIGH(1'b0)) uut (
        .clk(clk), .ce_n(ce_a), .rst_oe(rlo), .ld_en(ld_a), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(d_a), .dout_en(e_a), .ceo_n(co_a));

    // second store, enabled by the first one's cascade output
    serial_cfg_store #(.DEPTH(D), .RST_HIGH(1'b0)) uut_nxt (
        .clk(clk), .ce_n(co_a), .rst_oe(rlo), .ld_en(ld_b), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(d_b), .dout_en(e_b), .ceo_n(co_b));

    // standalone store, default active-high reset
    serial_cfg_store #(.DEPTH(D)) uut_hp (
        .clk(clk), .ce_n(ce_c), .rst_oe(rhi), .ld_en(ld_c), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(d_c), .dout_en(e_c), .ceo_n(co_c));

    // shared line with pull-up
    assign line = e_a ? d_a : (e_b ? d_b : 1'b1);

    // behavioural reference
    logic ma [D];
    logic mb [D];
    logic mc [D];
    int   ca = 0, cb = 0, cc = 0;

    always @(posedge clk) begin
        bit b_on;
        b_on = !ce_a && rlo && (ca == D);
        if (ld_a) ma[ld_addr] = ld_bit;
        if (ld_b) mb[ld_addr] = ld_bit;
        if (ld_c) mc[ld_addr] = ld_bit;
        if (!rlo) begin
            ca = 0;
            cb = 0;
        end else begin
            if (!ce_a && ca < D) ca++;
            if (b_on && cb < D) cb++;
        end
        if (rhi) cc = 0;
        else if (!ce_c && cc < D) cc++;
    end

    task automatic chk(input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
        end
    endtask

    task automatic compare();
        bit sa, sb, sc, ea, eb, ec, oa, ob, oc, lexp;
        sa = !ce_a && rlo;
        ea = sa && (ca < D);
        oa = !(sa && ca == D);
        sb = !oa && rlo;
        eb = sb && (cb < D);
        ob = !(sb && cb == D);
        sc = !ce_c && !rhi;
        ec = sc && (cc < D);
        oc = !(sc && cc == D);
        chk("R1 en_a", e_a, ea);
        chk("R1 en_b", e_b, eb);
        chk("R3 en_c", e_c, ec);
        chk("R5 ceo_a", co_a, oa);
        chk("R5 ceo_b", co_b, ob);
        chk("R6 ceo_c", co_c, oc);
        if (ea) chk("R8 dout_a", d_a, ma[ca]);
        if (eb) chk("R8 dout_b", d_b, mb[cb]);
        if (ec) chk("R9 dout_c", d_c, mc[cc]);
        lexp = ea ? ma[ca] : (eb ? mb[cb] : 1'b1);
        chk("R10 line", line, lexp);
        chk("R10 single_driver", (e_a && e_b), 1'b0);
    endtask

    task automatic step();
        @(posedge clk);
        #3;
        compare();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [D-1:0] pa, pb, pc;
        pa = 8'b1011_0010;
        pb = 8'b0110_1101;
        pc = 8'b1100_0101;
        rlo = 1'b0; rhi = 1'b1; ce_a = 1'b0; ce_c = 1'b0;
        ld_a = 1'b0; ld_b = 1'b0; ld_c = 1'b0; ld_bit = 1'b0; ld_addr = '0;

        // R9: fill the arrays while held in reset (R2 outputs checked each step)
        tag = "R9";
        for (int i = 0; i < D; i++) begin
            ld_addr = AW'(i);
            ld_a = 1'b1; ld_b = 1'b0; ld_c = 1'b0; ld_bit = pa[i];
            step();
            ld_a = 1'b0; ld_b = 1'b1; ld_bit = pb[i];
            step();
            ld_b = 1'b0; ld_c = 1'b1; ld_bit = pc[i];
            step();
        end
        ld_c = 1'b0;

        tag = "R2";
        repeat (3) step();

        // R10: stream the whole chain, then past the end (R6)
        tag = "R10";
        rlo = 1'b1; rhi = 1'b0;
        repeat (18) step();
        tag = "R6";
        repeat (4) step();

        // R5: cascade output follows chip-enable after the end
        tag = "R5";
        ce_a = 1'b1; repeat (2) step();
        ce_a = 1'b0; repeat (2) step();

        // R3: each polarity resets only its own stores
        tag = "R3";
        rlo = 1'b0; repeat (3) step();
        rlo = 1'b1; rhi = 1'b1; repeat (3) step();
        rhi = 1'b0; repeat (3) step();

        // R4: chip-enable removed mid-stream
        tag = "R4";
        ce_a = 1'b1; ce_c = 1'b1;
        repeat (4) step();

        // R7: resume where the read stopped
        tag = "R7";
        ce_a = 1'b0; ce_c = 1'b0;
        repeat (6) step();

        // R1: alternate chip-enable, advance only on enabled edges
        tag = "R1";
        rlo = 1'b0; rhi = 1'b1; step();
        rlo = 1'b1; rhi = 1'b0;
        for (int k = 0; k < 24; k++) begin
            ce_a = k[0];
            ce_c = ~k[0];
            step();
        end
        ce_a = 1'b0; ce_c = 1'b0;
        repeat (20) step();

        finish_run();
    end

endmodule